// File: doc/BRIEF.md
# Byte-Link Receiver with FIFO-Driven Flow Control

This block is the receive end of a point-to-point link that carries one byte per rising edge of a link clock supplied by the sender. The block oversamples the link clock and data in its own clock domain and detects each rising edge of the link clock. It collects the bytes it sees into 32-bit words and stores the words in a four-entry receive FIFO. A host reads the words through a single-cycle pop strobe.

An acknowledge output tells the sender whether it may start another word. The acknowledge is computed from FIFO occupancy. It drops once three entries are filled, so the FIFO normally acts as three deep. The fourth entry is kept for a word the sender had already started when the acknowledge fell.

The enable input controls a start-up handshake. While the receiver is disabled, the acknowledge stays low and link traffic is ignored. When the receiver is enabled, the acknowledge rises in the same cycle. A service request output first rises on the first link-clock edge after enable. After that, it follows whether the FIFO holds data.

Top module: `lnk_rx_port`

## Requirements
- R1: While `rx_en` is low, `lnk_ack` is low, including during and right after reset.
- R2: When `rx_en` goes high with fewer than three words stored, `lnk_ack` is high in that same cycle (combinational path, no register).
- R3: With `rx_en` high, `lnk_ack` is low whenever the FIFO holds three or more words, and high whenever it holds fewer than three.
- R4: Bytes are assembled least-significant byte first: the first byte after a word boundary lands in bits 7:0 and the fourth in bits 31:24. The word enters the FIFO when its fourth byte arrives.
- R5: The FIFO stores up to four words and returns them in arrival order. A word that is completed while three words are already stored is kept in the fourth entry and is not lost.
- R6: After `rx_en` rises, `rx_req` stays low until a rising edge of `lnk_clk` is seen. It is high within three `clk` cycles of that edge, even before any word is complete.
- R7: While enabled, `rx_req` is high whenever the FIFO holds a word. A pop that empties the FIFO, with no new link edge, leaves `rx_req` low.
- R8: A pop on an empty FIFO leaves `rd_data` unchanged and sets `rd_underflow`. `rd_underflow` stays high until reset. A pop on a non-empty FIFO places the oldest word on `rd_data` one cycle later.
- R9: Link bytes received while `rx_en` is low are ignored. Lowering `rx_en` discards a partly assembled word, so the next word starts again at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock, faster than the link clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Receiver enable |
| lnk_clk | input | 1 | Link clock from the sender; data is taken on its rising edge |
| lnk_data | input | 8 | Link data byte |
| lnk_ack | output | 1 | Flow-control acknowledge to the sender |
| rd_pop | input | 1 | Host pop strobe, one word per cycle |
| rd_data | output | 32 | Last word popped |
| rx_req | output | 1 | Receive service request |
| rd_underflow | output | 1 | Sticky flag for a pop on an empty FIFO |

## Verification
The packing is tried with directed words whose four bytes are all distinct, and then with random words. Distinct bytes expose lane swaps or a wrong byte order.

Single words followed by pops show that the word boundary is found correctly. Partial words cut off by a disable show whether the byte counter restarts. Two words sent back to back when two entries are full push the FIFO to its fourth entry, which separates the normal three-deep threshold from real overflow.

Random interleaving of words and pops checks the acknowledge and the service request against the occupancy the bench predicts after every step.

// File: rtl/lnk_rx_pkg.sv
package lnk_rx_pkg;
  localparam int unsigned LNK_BYTE_W      = 8;
  localparam int unsigned LNK_LANES       = 4;
  localparam int unsigned LNK_FIFO_DEPTH  = 4;
  localparam int unsigned LNK_ACK_LIMIT   = 3;
  localparam int unsigned LNK_SYNC_STAGES = 2;
endpackage

// File: rtl/lnk_rx_sync.sv
module lnk_rx_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lnk_clk_i,
  input  logic [BYTE_W-1:0] lnk_data_i,
  output logic              rise_o,
  output logic [BYTE_W-1:0] data_o
);
  logic              clk_d [STAGES];
  logic              clk_q [STAGES];
  logic [BYTE_W-1:0] dat_d [STAGES];
  logic [BYTE_W-1:0] dat_q [STAGES];
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign clk_d[g] = lnk_clk_i;
      assign dat_d[g] = lnk_data_i;
    end else begin : g_next
      assign clk_d[g] = clk_q[g-1];
      assign dat_d[g] = dat_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        clk_q[g] <= 1'b0;
        dat_q[g] <= '0;
      end else begin
        clk_q[g] <= clk_d[g];
        dat_q[g] <= dat_d[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= clk_q[STAGES-1];
  end

  assign rise_o = clk_q[STAGES-1] & ~last_q;
  assign data_o = dat_q[STAGES-1];
endmodule

// File: rtl/lnk_rx_packer.sv
module lnk_rx_packer #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned WORD_W = BYTE_W * LANES,
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              cap_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);

  logic [LANE_W-1:0] lane_q, lane_d;
  logic [BYTE_W-1:0] held_q [LANES-1];
  logic [BYTE_W-1:0] held_d [LANES-1];
  logic              push_q, push_d;
  logic [WORD_W-1:0] word_q, word_d, full_word;

  for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
    assign full_word[g*BYTE_W +: BYTE_W] = held_q[g];
  end
  assign full_word[(LANES-1)*BYTE_W +: BYTE_W] = byte_i;

  always_comb begin
    lane_d = lane_q;
    held_d = held_q;
    push_d = 1'b0;
    word_d = word_q;
    if (!en_i) begin
      lane_d = '0;
    end else if (cap_i) begin
      if (lane_q == LAST) begin
        word_d = full_word;
        push_d = 1'b1;
        lane_d = '0;
      end else begin
        held_d[lane_q] = byte_i;
        lane_d = LANE_W'(lane_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      push_q <= 1'b0;
      word_q <= '0;
      for (int i = 0; i < LANES - 1; i++) held_q[i] <= '0;
    end else begin
      lane_q <= lane_d;
      push_q <= push_d;
      word_q <= word_d;
      held_q <= held_d;
    end
  end

  assign push_o = push_q;
  assign word_o = word_q;

  AST_WORD_ON_LAST_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> $past(en_i && cap_i && (lane_q == LAST))); // R4
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (lane_q == '0) && !push_o); // R9
endmodule

// File: rtl/lnk_rx_fifo.sv
module lnk_rx_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [LVL_W-1:0] level_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W-1:0] cnt_q, cnt_d;
  logic             do_wr, do_rd;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == LVL_W'(DEPTH));
  assign do_wr   = push_i && !full_o;
  assign do_rd   = pop_i && !empty_o;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_wr) wr_d = (wr_q == PTR_LAST) ? '0 : PTR_W'(wr_q + 1'b1);
    if (do_rd) rd_d = (rd_q == PTR_LAST) ? '0 : PTR_W'(rd_q + 1'b1);
    if (do_wr && !do_rd)      cnt_d = LVL_W'(cnt_q + 1'b1);
    else if (do_rd && !do_wr) cnt_d = LVL_W'(cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wr_q] <= data_i;
  end

  assign head_o  = mem_q[rd_q];
  assign level_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |-> !full_o); // R5
  AST_LEVEL_TRACKS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (level_o == LVL_W'($past(level_o) + 1'b1))); // R5
endmodule

// File: rtl/lnk_rx_flow.sv
module lnk_rx_flow #(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned ACK_LIMIT = 3,
  localparam int unsigned LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic             pop_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             empty_i,
  output logic             ack_o,
  output logic             req_o
);
  logic seen_q, seen_d;

  always_comb begin
    seen_d = seen_q;
    if (!en_i)       seen_d = 1'b0;
    else if (rise_i) seen_d = 1'b1;
    else if (pop_i)  seen_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end

  assign ack_o = en_i && (level_i < LVL_W'(ACK_LIMIT));
  assign req_o = en_i && (seen_q || !empty_i);

  AST_REQ_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && rise_i) |=> (!en_i || req_o)); // R6
endmodule

// File: rtl/lnk_rx_port.sv
module lnk_rx_port #(
  parameter int unsigned BYTE_W     = lnk_rx_pkg::LNK_BYTE_W,
  parameter int unsigned LANES      = lnk_rx_pkg::LNK_LANES,
  parameter int unsigned DEPTH      = lnk_rx_pkg::LNK_FIFO_DEPTH,
  parameter int unsigned ACK_LIMIT  = lnk_rx_pkg::LNK_ACK_LIMIT,
  parameter int unsigned SYNC_STAGE = lnk_rx_pkg::LNK_SYNC_STAGES,
  localparam int unsigned WORD_W    = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              lnk_clk,
  input  logic [BYTE_W-1:0] lnk_data,
  output logic              lnk_ack,
  input  logic              rd_pop,
  output logic [WORD_W-1:0] rd_data,
  output logic              rx_req,
  output logic              rd_underflow
);
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              rise;
  logic [BYTE_W-1:0] smp_byte;
  logic              pk_push;
  logic [WORD_W-1:0] pk_word;
  logic [WORD_W-1:0] fifo_head;
  logic [LVL_W-1:0]  fifo_level;
  logic              fifo_empty, fifo_full;
  logic [WORD_W-1:0] rd_data_d;
  logic              uf_d, uf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  lnk_rx_sync #(.STAGES(SYNC_STAGE), .BYTE_W(BYTE_W)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .lnk_clk_i(lnk_clk), .lnk_data_i(lnk_data),
    .rise_o(rise), .data_o(smp_byte)
  );

  lnk_rx_packer #(.BYTE_W(BYTE_W), .LANES(LANES)) u_packer (
    .clk(clk), .rst_n(rst_int_n), .en_i(rx_en), .cap_i(rise), .byte_i(smp_byte),
    .push_o(pk_push), .word_o(pk_word)
  );

  lnk_rx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_int_n), .push_i(pk_push), .data_i(pk_word), .pop_i(rd_pop),
    .head_o(fifo_head), .level_o(fifo_level), .empty_o(fifo_empty), .full_o(fifo_full)
  );

  lnk_rx_flow #(.DEPTH(DEPTH), .ACK_LIMIT(ACK_LIMIT)) u_flow (
    .clk(clk), .rst_n(rst_int_n), .en_i(rx_en), .rise_i(rise), .pop_i(rd_pop),
    .level_i(fifo_level), .empty_i(fifo_empty), .ack_o(lnk_ack), .req_o(rx_req)
  );

  always_comb begin
    rd_data_d = rd_data;
    uf_d      = uf_q;
    if (rd_pop) begin
      if (fifo_empty) uf_d = 1'b1;
      else            rd_data_d = fifo_head;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_data <= '0;
      uf_q    <= 1'b0;
    end else begin
      rd_data <= rd_data_d;
      uf_q    <= uf_d;
    end
  end
  assign rd_underflow = uf_q;

  AST_ACK_LOW_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_int_n)
    fifo_full |-> !lnk_ack); // R3
  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_underflow |=> rd_underflow); // R8
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_pop && fifo_empty) |=> $stable(rd_data)); // R8
  AST_DATA_WAKES_REQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_en && !fifo_empty) |-> rx_req); // R7
endmodule

// File: tb/lnk_rx_port_bench.sv
module lnk_rx_port_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_en;
  logic        lnk_clk;
  logic [7:0]  lnk_data;
  logic        lnk_ack;
  logic        rd_pop;
  logic [31:0] rd_data;
  logic        rx_req;
  logic        rd_underflow;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;
  logic [31:0] mdl_q[$];
  logic [31:0] last_word = '0;
  logic        exp_uf = 1'b0;

  always #10 clk = ~clk;

  lnk_rx_port u_lnk_rx_port (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .lnk_clk(lnk_clk), .lnk_data(lnk_data),
    .lnk_ack(lnk_ack), .rd_pop(rd_pop), .rd_data(rd_data), .rx_req(rx_req),
    .rd_underflow(rd_underflow)
  );

  function automatic logic exp_ack(input logic en, input int unsigned lvl);
    return en && (lvl < 3);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk) lnk_data = b;
    @(negedge clk) lnk_clk = 1'b1;
    repeat (4) @(negedge clk);
    lnk_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w, input bit model);
    for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8]);
    if (model) mdl_q.push_back(w);
  endtask

  task automatic pop_chk(input string tag);
    @(negedge clk) rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
    if (mdl_q.size() == 0) exp_uf = 1'b1;
    else last_word = mdl_q.pop_front();
    check({tag, " rd_data"}, rd_data, last_word);
    check({tag, " underflow"}, {31'd0, rd_underflow}, {31'd0, exp_uf});
  endtask

  task automatic state_chk(input string tag);
    check({tag, " R3 ack"}, {31'd0, lnk_ack}, {31'd0, exp_ack(rx_en, mdl_q.size())});
    check({tag, " R7 req"}, {31'd0, rx_req}, {31'd0, rx_en && (mdl_q.size() != 0)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; rx_en = 1'b0; lnk_clk = 1'b0; lnk_data = '0; rd_pop = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ack in reset", {31'd0, lnk_ack}, 32'd0);
    check("R7 req in reset", {31'd0, rx_req}, 32'd0);
    check("R8 underflow reset", {31'd0, rd_underflow}, 32'd0);
    check("R8 rd_data reset", rd_data, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ack after reset", {31'd0, lnk_ack}, 32'd0);

    // R9: traffic while disabled is dropped
    send_word(32'hDEAD_BEEF, 1'b0);
    check("R9 req after disabled bytes", {31'd0, rx_req}, 32'd0);
    check("R1 ack disabled", {31'd0, lnk_ack}, 32'd0);

    // R2 and R6: enable handshake
    @(negedge clk) rx_en = 1'b1;
    #1;
    check("R2 ack on enable", {31'd0, lnk_ack}, 32'd1);
    check("R6 req before edge", {31'd0, rx_req}, 32'd0);
    send_byte(8'hA1);
    check("R6 req after first edge", {31'd0, rx_req}, 32'd1);
    send_byte(8'hA2);
    @(negedge clk) rx_en = 1'b0;
    #1;
    check("R1 ack on disable", {31'd0, lnk_ack}, 32'd0);
    repeat (2) @(negedge clk);
    rx_en = 1'b1;
    send_word(32'h4433_2211, 1'b1);
    check("R7 req with data", {31'd0, rx_req}, 32'd1);
    pop_chk("R4 R9 byte order and partial discard");
    state_chk("R7 after emptying pop");
    pop_chk("R8 empty pop");

    // R3 and R5: threshold and fourth slot
    send_word(32'h0302_0100, 1'b1); state_chk("R3 one word");
    send_word(32'h1312_1110, 1'b1); state_chk("R3 two words");
    send_word(32'h2322_2120, 1'b1); state_chk("R3 three words");
    pop_chk("R5 order 1"); state_chk("R3 back to two");
    send_word(32'h3332_3130, 1'b1);
    send_word(32'h4342_4140, 1'b1);
    check("R5 fourth slot ack", {31'd0, lnk_ack}, 32'd0);
    state_chk("R5 four words");
    for (int i = 0; i < 4; i++) begin
      pop_chk("R5 order drain");
      state_chk("R5 drain state");
    end

    // random mix, R3 R4 R5 R7
    for (int it = 0; it < 80; it++) begin
      int unsigned r;
      r = $urandom % 4;
      if ((r < 2 && mdl_q.size() < 3) || mdl_q.size() == 0) begin
        check("R3 ack before word", {31'd0, lnk_ack}, 32'd1);
        send_word($urandom, 1'b1);
      end else begin
        pop_chk("R4 R5 random pop");
      end
      state_chk("R3 R7 random");
    end
    while (mdl_q.size() != 0) pop_chk("R5 final drain");
    pop_chk("R8 final empty pop");
    state_chk("R7 final");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule